// File: doc/BRIEF.md
# Per-Block Write Guard with Pin-Qualified Locks

This block keeps the program/erase protection of a row of memory blocks. Each block has two bits of state: a protect bit, which software sets and clears with commands, and a lock bit, which can be set by command but not cleared by one. A single write-guard pin decides what a lock means. While the pin is high, locks are overridden and the protect bit alone governs the block. While the pin is low, a locked block is held protected and refuses protect changes.

Each block also stores the protect value it had just before it was locked. When the pin goes low, locked blocks are forced protected. When the pin goes high again, each locked block gets that stored value back. The command source gives an operation code and a block index. The array controller reads one permission bit per block, and a status port returns the lock and protect bits of one selected block.

Top module: `blk_guard_top`

## Requirements
- R1: After the power-up reset (`rst_n` low) every block is protected and unlocked, its stored pre-lock value is 1, and the registered pin level is taken as high.
- R2: `pe_allow[i]` is 1 exactly when block i is unprotected and, in addition, the registered pin level is high or the block is unlocked.
- R3: A command with `cmd_op` 2'b01 sets the protect bit of block `cmd_idx`, and 2'b10 clears it. This happens when the block is unlocked or the registered pin level is high. Code 2'b00 does nothing.
- R4: While the registered pin level is low, 2'b01 and 2'b10 have no effect on a locked block.
- R5: `cmd_op` 2'b11 sets the lock bit and the protect bit of the indexed block at any pin level. If the block was unlocked, its protect bit from before the command is stored as the pre-lock value. If it was already locked, the stored value is kept.
- R6: Once set, a lock bit stays set until the power-up reset or `lock_clr`.
- R7: On a high-to-low pin change, every locked block becomes protected. Unlocked blocks keep their protect bit.
- R8: On a low-to-high pin change, every locked block takes its stored pre-lock value as its protect bit. Unlocked blocks keep their protect bit.
- R9: The pin is registered. A pin change is a cycle in which `wp_in` differs from the registered level. In that cycle, any command is discarded, and the pin change takes effect at the same clock edge.
- R10: `lock_clr`, sampled on the clock, unlocks and protects every block and sets every stored pre-lock value to 1. It overrides a pin change and a command in the same cycle.
- R11: `rd_status` is combinational. Bit 1 is the lock bit and bit 0 is the protect bit of block `rd_idx`.
- R12: A `cmd_idx` at or above `NUM_BLOCKS` changes nothing, and an `rd_idx` at or above `NUM_BLOCKS` reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| lock_clr | input | 1 | Synchronous lock clear, all blocks left protected |
| wp_in | input | 1 | Write-guard pin level |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 protect, 10 unprotect, 11 lock |
| cmd_idx | input | IDX_W | Target block of the command |
| rd_idx | input | IDX_W | Block selected for the status read |
| rd_status | output | 2 | {lock, protect} of the selected block |
| pe_allow | output | NUM_BLOCKS | Program/erase permission per block |

## Verification
The bench builds the block with `NUM_BLOCKS` = 6, so the 3-bit index fields can carry the codes 6 and 7. This exercises the range-checked variant of the index decode and status read, and with it R12. With only six blocks, random commands hit the same block often. Lock, pin-change, restore sequences therefore recur many times within a few thousand cycles, including commands that coincide with pin changes and with `lock_clr`.

// File: rtl/blk_guard_pkg.sv
package blk_guard_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'b00,
      OP_PROT   = 2'b01,
      OP_UNPROT = 2'b10,
      OP_LOCK   = 2'b11
   } guard_op_e;

endpackage

// File: rtl/blk_guard_wp_edge.sv
module blk_guard_wp_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic wp_in,
   output logic wp_lvl,
   output logic wp_rise,
   output logic wp_fall
);

   logic wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wp_q <= 1'b1;
      else        wp_q <= wp_in;
   end

   assign wp_lvl  = wp_q;
   assign wp_rise = wp_in & ~wp_q;
   assign wp_fall = ~wp_in & wp_q;

   // R9
   wp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wp_lvl == $past(wp_in)));

endmodule

// File: rtl/blk_guard_cell.sv
module blk_guard_cell
   import blk_guard_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lock_clr,
   input  logic      wp_lvl,
   input  logic      wp_rise,
   input  logic      wp_fall,
   input  logic      hit,
   input  guard_op_e op,
   output logic      lock_o,
   output logic      prot_o,
   output logic      allow_o
);

   logic lock_q, prot_q, save_q;
   logic lock_d, prot_d, save_d;
   logic may_edit;

   assign may_edit = wp_lvl | ~lock_q;

   always_comb begin
      lock_d = lock_q;
      prot_d = prot_q;
      save_d = save_q;
      if (lock_clr) begin
         lock_d = 1'b0;
         prot_d = 1'b1;
         save_d = 1'b1;
      end else if (wp_fall) begin
         if (lock_q) prot_d = 1'b1;
      end else if (wp_rise) begin
         if (lock_q) prot_d = save_q;
      end else if (hit) begin
         unique case (op)
            OP_PROT:   if (may_edit) prot_d = 1'b1;
            OP_UNPROT: if (may_edit) prot_d = 1'b0;
            OP_LOCK: begin
               if (!lock_q) save_d = prot_q;
               lock_d = 1'b1;
               prot_d = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         prot_q <= 1'b1;
         save_q <= 1'b1;
      end else begin
         lock_q <= lock_d;
         prot_q <= prot_d;
         save_q <= save_d;
      end
   end

   assign lock_o  = lock_q;
   assign prot_o  = prot_q;
   assign allow_o = ~prot_q & may_edit;

   // R6
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !lock_clr) |=> lock_q);

   // R7
   fall_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_fall && lock_q && !lock_clr) |=> (prot_q && lock_q));

   // R8
   rise_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_rise && lock_q && !lock_clr) |=> (prot_q == $past(save_q)));

   // R10
   clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_clr |=> (!lock_q && prot_q && save_q));

   // R4
   low_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_lvl && lock_q && !wp_rise && !lock_clr) |=> prot_q);

endmodule

// File: rtl/blk_guard_top.sv
module blk_guard_top
   import blk_guard_pkg::*;
#(
   parameter  int NUM_BLOCKS = 8,
   localparam int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lock_clr,
   input  logic                  wp_in,
   input  logic                  cmd_valid,
   input  logic [1:0]            cmd_op,
   input  logic [IDX_W-1:0]      cmd_idx,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [1:0]            rd_status,
   output logic [NUM_BLOCKS-1:0] pe_allow
);

   localparam int  SPAN     = 1 << IDX_W;
   localparam bit  FULL_MAP = (SPAN == NUM_BLOCKS);

   if (NUM_BLOCKS < 2) begin : g_bad_count
      $error("blk_guard_top: NUM_BLOCKS must be at least 2");
   end

   logic wp_lvl, wp_rise, wp_fall;
   logic [NUM_BLOCKS-1:0] lock_v, prot_v;
   guard_op_e op_e;

   assign op_e = guard_op_e'(cmd_op);

   blk_guard_wp_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .wp_in   (wp_in),
      .wp_lvl  (wp_lvl),
      .wp_rise (wp_rise),
      .wp_fall (wp_fall)
   );

   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
      logic hit;
      assign hit = cmd_valid && (cmd_idx == IDX_W'(i));

      blk_guard_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .lock_clr (lock_clr),
         .wp_lvl   (wp_lvl),
         .wp_rise  (wp_rise),
         .wp_fall  (wp_fall),
         .hit      (hit),
         .op       (op_e),
         .lock_o   (lock_v[i]),
         .prot_o   (prot_v[i]),
         .allow_o  (pe_allow[i])
      );
   end

   if (FULL_MAP) begin : g_rd_full
      always_comb rd_status = {lock_v[rd_idx], prot_v[rd_idx]};
   end else begin : g_rd_checked
      always_comb begin
         rd_status = 2'b00;
         for (int k = 0; k < NUM_BLOCKS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_status = {lock_v[k], prot_v[k]};
         end
      end
   end

endmodule

// File: tb/tb_blk_guard_top.sv
module tb_blk_guard_top;
   localparam int NB = 6;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n, lock_clr, wp_in, cmd_valid;
   logic [1:0] cmd_op;
   logic [IW-1:0] cmd_idx, rd_idx;
   logic [1:0] rd_status;
   logic [NB-1:0] pe_allow;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;
   bit mL[NB], mP[NB], mS[NB];
   bit mW;

   always #4 clk = ~clk;

   blk_guard_top #(.NUM_BLOCKS(NB)) dut (
      .clk(clk), .rst_n(rst_n), .lock_clr(lock_clr), .wp_in(wp_in),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
      .rd_idx(rd_idx), .rd_status(rd_status), .pe_allow(pe_allow)
   );

   function automatic void model_reset();
      for (int i = 0; i < NB; i++) begin mL[i] = 0; mP[i] = 1; mS[i] = 1; end
      mW = 1;
   endfunction

   function automatic void model_step(bit w, bit v, bit [1:0] op, int idx, bit clr);
      if (clr) begin
         for (int i = 0; i < NB; i++) begin mL[i] = 0; mP[i] = 1; mS[i] = 1; end
      end else if (w != mW) begin
         for (int i = 0; i < NB; i++)
            if (mL[i]) mP[i] = w ? mS[i] : 1'b1;
      end else if (v && idx < NB) begin
         case (op)
            2'b01: if (mW || !mL[idx]) mP[idx] = 1;
            2'b10: if (mW || !mL[idx]) mP[idx] = 0;
            2'b11: begin
               if (!mL[idx]) mS[idx] = mP[idx];
               mL[idx] = 1; mP[idx] = 1;
            end
            default: ;
         endcase
      end
      mW = w;
   endfunction

   function automatic bit [NB-1:0] exp_allow();
      bit [NB-1:0] a;
      for (int i = 0; i < NB; i++) a[i] = !mP[i] && (mW || !mL[i]);
      return a;
   endfunction

   function automatic bit [1:0] exp_status(int r);
      if (r >= NB) return 2'b00;
      return {mL[r], mP[r]};
   endfunction

   task automatic check(string tag);
      bit [NB-1:0] ea = exp_allow();
      bit [1:0] es = exp_status(int'(rd_idx));
      nchk++;
      if (pe_allow !== ea) begin
         nfail++;
         $display("FAIL %s R2 pe_allow actual %b expected %b", tag, pe_allow, ea);
      end
      nchk++;
      if (rd_status !== es) begin
         nfail++;
         $display("FAIL %s R11 rd_status[%0d] actual %b expected %b", tag, rd_idx, rd_status, es);
      end
   endtask

   task automatic step(bit w, bit v, bit [1:0] op, int idx, int rd, bit clr, string tag);
      @(negedge clk);
      wp_in = w; cmd_valid = v; cmd_op = op; cmd_idx = IW'(idx);
      rd_idx = IW'(rd); lock_clr = clr;
      model_step(w, v, op, idx, clr);
      @(posedge clk);
      #1;
      check(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; lock_clr = 0; wp_in = 1; cmd_valid = 0;
      cmd_op = 2'b00; cmd_idx = '0; rd_idx = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      check("R1 reset blk0");
      rd_idx = 3'd4; #1;
      check("R1 reset blk4");

      step(0, 0, 2'b00, 0, 1, 0, "R7 fall unlocked");
      step(0, 1, 2'b10, 2, 2, 0, "R3 unprotect low");
      step(0, 1, 2'b11, 2, 2, 0, "R5 lock low");
      step(0, 1, 2'b10, 2, 2, 0, "R4 unprotect ignored");
      step(0, 1, 2'b01, 2, 2, 0, "R4 protect ignored");
      step(1, 0, 2'b00, 2, 2, 0, "R8 rise restore");
      step(1, 1, 2'b01, 2, 2, 0, "R3 protect high locked");
      step(1, 1, 2'b10, 2, 2, 0, "R3 unprotect high locked");
      step(0, 1, 2'b10, 5, 5, 0, "R9 command during fall");
      step(0, 0, 2'b00, 0, 2, 0, "R7 locked forced");
      step(0, 1, 2'b01, 6, 6, 0, "R12 out of range");
      step(0, 1, 2'b11, 7, 7, 0, "R12 lock out of range");
      step(1, 1, 2'b10, 3, 2, 1, "R10 clear overrides");
      step(1, 1, 2'b11, 3, 3, 0, "R5 lock high");
      step(0, 0, 2'b00, 0, 3, 0, "R6 lock kept low");
      step(1, 0, 2'b00, 0, 3, 0, "R6 lock kept rise");
      step(1, 1, 2'b10, 3, 3, 0, "R6 unprotect keeps lock");
      step(1, 1, 2'b00, 3, 3, 0, "R3 none code");

      for (int n = 0; n < 4000; n++) begin
         bit w = (($urandom % 10) == 0) ? !mW : mW;
         bit c = (($urandom % 120) == 0);
         bit v = (($urandom % 4) != 0);
         step(w, v, 2'($urandom), int'($urandom % 8), int'($urandom % 8), c, "R2 R11 random");
      end

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule